// File: doc/BRIEF.md
# Receive FIFO with Threshold Interrupt

This block sits behind the receive shifter of a 16550-style serial port. Incoming characters are pushed into a 16-entry first-in first-out store and stay there until the host pops them. An interrupt request goes high once the number of stored characters reaches a threshold that software chooses.

An 8-bit write-only control register drives the block. Bit 0 enables the FIFOs. Bit 1 flushes the receive FIFO. Bit 2 asks a companion transmit FIFO to flush. Bits 7:6 pick the threshold. The two flush bits act only on the write that carries them and are not stored. Any change of the enable bit, in either direction, flushes both FIFOs. The transmit flush leaves the block as a one-cycle pulse.

Top module: `rx_fifo_trigger`

## Requirements
- R1: After reset the FIFO is disabled and empty. `fillLevel` is 0, `rxIrq`, `overrun` and `txFlushPulse` are low, `popData` is 0, and the threshold selection is 0.
- R2: A register write whose bit 0 differs from the current enable state stores the new state. At the same clock edge the receive FIFO is emptied and `overrun` is cleared. A transmit flush pulse follows.
- R3: A write with bit 1 set empties the receive FIFO and clears `overrun` at that edge. The bit is not stored, so a later write with bit 1 clear leaves the contents intact.
- R4: A write with bit 2 set, or one that changes bit 0, drives `txFlushPulse` high for exactly the one cycle after the write edge. Any other write leaves the pulse low.
- R5: Bits 7:6 of the last write select the threshold: 0 selects 1 character, 1 selects 4, 2 selects 8, and 3 selects 14.
- R6: `rxIrq` is high exactly when the FIFO is enabled and `fillLevel` is at or above the selected threshold.
- R7: Characters come out in the order they were accepted. `fillLevel` counts from 0 to 16, `fifoEmpty` is high at 0 and `fifoFull` is high at 16.
- R8: A push while full is dropped, even if a pop happens in the same cycle, and it sets `overrun`. `overrun` stays set until a receive flush or reset.
- R9: A pop while empty leaves `popData` and `fillLevel` unchanged.
- R10: While the FIFO is disabled, pushes are ignored and the FIFO stays empty.
- R11: If a receive flush coincides with a push or a pop, the flush wins. The FIFO ends empty and `popData` keeps its value.
- R12: A pop of a non-empty FIFO loads the oldest character into `popData` at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write value |
| pushValid | input | 1 | Received character present |
| pushData | input | 8 | Received character |
| popReq | input | 1 | Host reads one character |
| popData | output | 8 | Last character read |
| fillLevel | output | 5 | Number of stored characters |
| fifoEmpty | output | 1 | FIFO holds nothing |
| fifoFull | output | 1 | FIFO holds 16 characters |
| overrun | output | 1 | Sticky flag: a character was dropped |
| rxIrq | output | 1 | Threshold interrupt request |
| txFlushPulse | output | 1 | One-cycle flush command to the transmit FIFO |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge. They also assume that `cfgData` only matters when `cfgWr` is high. Writes may arrive back to back, and push and pop may coincide with a flush, so the properties are written to hold for any such mix. The stimulus drives all inputs from fully defined random or directed values after reset. Control writes are kept sparse so that the FIFO can fill up and cross every threshold.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       flushRx;
    logic       fifoOn;
    logic [1:0] thrSel;
  } ctrlStrobe_t;

  function automatic int unsigned thrCount(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  output ctrlStrobe_t      strobe,
  output logic             txFlushPulse
);
  localparam int EN_BIT  = 0;
  localparam int RXF_BIT = 1;
  localparam int TXF_BIT = 2;
  localparam int THR_LO  = CFG_W - 2;

  logic       enReg;
  logic [1:0] thrReg;
  logic       enChange;
  logic       txReq;

  assign enChange = cfgWr && (cfgData[EN_BIT] != enReg);
  assign txReq    = enChange || (cfgWr && cfgData[TXF_BIT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg        <= 1'b0;
      thrReg       <= 2'd0;
      txFlushPulse <= 1'b0;
    end else begin
      txFlushPulse <= txReq;
      if (cfgWr) begin
        enReg  <= cfgData[EN_BIT];
        thrReg <= cfgData[THR_LO +: 2];
      end
    end
  end

  always_comb begin
    strobe.flushRx = enChange || (cfgWr && cfgData[RXF_BIT]);
    strobe.fifoOn  = enReg;
    strobe.thrSel  = thrReg;
  end

  // R4: the transmit flush pulse only follows a register write
  p_tx_after_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    txFlushPulse |-> $past(cfgWr));

  // R2: a change of the enable bit is always followed by a transmit flush
  p_toggle_tx_r2: assert property (@(posedge clk) disable iff (!rstN)
    enChange |=> txFlushPulse);

endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic                         pushValid,
  input  logic [DATA_W-1:0]            pushData,
  input  logic                         popReq,
  output logic [DATA_W-1:0]            popData,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel,
  output logic                         fifoEmpty,
  output logic                         fifoFull,
  output logic                         overrun,
  output logic                         rxIrq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pushOk, popOk, dropHit;
  logic [CNT_W-1:0]  thrLevel;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign pushOk    = pushValid && strobe.fifoOn && !fifoFull && !strobe.flushRx;
  assign popOk     = popReq && !fifoEmpty && !strobe.flushRx;
  assign dropHit   = pushValid && strobe.fifoOn && fifoFull && !strobe.flushRx;
  assign thrLevel  = CNT_W'(thrCount(strobe.thrSel));
  assign fillLevel = count;
  assign rxIrq     = strobe.fifoOn && (count >= thrLevel);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
      popData <= '0;
    end else if (strobe.flushRx) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        rdPtr   <= nextPtr(rdPtr);
        popData <= store[rdPtr];
      end
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (dropHit) overrun <= 1'b1;
    end
  end

  // R7: the fill level never passes the depth
  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R11: a receive flush always leaves the FIFO empty
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushRx |=> fifoEmpty);

  // R8: a push into a full FIFO is dropped and flags overrun
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && pushValid && strobe.fifoOn && !strobe.flushRx && !popReq)
      |=> (overrun && fifoFull));

  // R8: overrun stays set until a receive flush
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !strobe.flushRx) |=> overrun);

  // R9: a pop while empty keeps the read value
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && popReq) |=> $stable(popData));

  // R10: while disabled the FIFO cannot gain characters
  p_off_no_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.fifoOn && fifoEmpty) |=> fifoEmpty);

endmodule

// File: rtl/rx_fifo_trigger.sv
module rx_fifo_trigger
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CFG_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWr,
  input  logic [CFG_W-1:0]           cfgData,
  input  logic                       pushValid,
  input  logic [DATA_W-1:0]          pushData,
  input  logic                       popReq,
  output logic [DATA_W-1:0]          popData,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       fifoEmpty,
  output logic                       fifoFull,
  output logic                       overrun,
  output logic                       rxIrq,
  output logic                       txFlushPulse
);
  ctrlStrobe_t strobe;

  rxq_ctrl #(.CFG_W(CFG_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWr        (cfgWr),
    .cfgData      (cfgData),
    .strobe       (strobe),
    .txFlushPulse (txFlushPulse)
  );

  rxq_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pushValid (pushValid),
    .pushData  (pushData),
    .popReq    (popReq),
    .popData   (popData),
    .fillLevel (fillLevel),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .overrun   (overrun),
    .rxIrq     (rxIrq)
  );

  // R6: the interrupt never fires with the FIFO empty
  p_irq_needs_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> !fifoEmpty);

endmodule

// File: tb/tb_rx_fifo_trigger.sv
module tb_rx_fifo_trigger;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = '0;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic [4:0] fillLevel;
  logic       fifoEmpty, fifoFull, overrun, rxIrq, txFlushPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_fifo_trigger dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .pushValid(pushValid), .pushData(pushData), .popReq(popReq),
    .popData(popData), .fillLevel(fillLevel), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .overrun(overrun), .rxIrq(rxIrq),
    .txFlushPulse(txFlushPulse)
  );

  // bench model
  logic [7:0] mq [16];
  int         mCnt = 0;
  logic       mEn = 0;
  logic [1:0] mThr = 0;
  logic       mOvr = 0;
  logic [7:0] mPop = 0;
  logic       mTx = 0;

  function automatic int thrOf(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic logic expIrq();
    return mEn && (mCnt >= thrOf(mThr));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic wr, input logic [7:0] d,
                           input logic psh, input logic [7:0] pd,
                           input logic pp);
    logic flush;
    logic tx;
    flush = wr && ((d[0] != mEn) || d[1]);
    tx    = wr && ((d[0] != mEn) || d[2]);
    if (flush) begin
      mCnt = 0;
      mOvr = 0;
    end else begin
      int pre;
      pre = mCnt;
      if (pp && pre > 0) begin
        mPop = mq[0];
        for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
        mCnt--;
      end
      if (psh && mEn) begin
        if (pre < 16) begin
          mq[mCnt] = pd;
          mCnt++;
        end else begin
          mOvr = 1;
        end
      end
    end
    if (wr) begin
      mEn  = d[0];
      mThr = d[7:6];
    end
    mTx = tx;
  endtask

  task automatic compareAll();
    chk("R7 fillLevel", fillLevel, mCnt);
    chk("R7 fifoEmpty", fifoEmpty, mCnt == 0);
    chk("R7 fifoFull", fifoFull, mCnt == 16);
    chk("R12 popData", popData, mPop);
    chk("R8 overrun", overrun, mOvr);
    chk("R6 rxIrq", rxIrq, expIrq());
    chk("R4 txFlushPulse", txFlushPulse, mTx);
  endtask

  task automatic step(input logic wr, input logic [7:0] d,
                      input logic psh, input logic [7:0] pd,
                      input logic pp);
    cfgWr = wr; cfgData = d; pushValid = psh; pushData = pd; popReq = pp;
    @(posedge clk);
    modelStep(wr, d, psh, pd, pp);
    #2;
    cfgWr = 0; pushValid = 0; popReq = 0;
    compareAll();
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 8'h00, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #2;
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 fillLevel", fillLevel, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 popData", popData, 0);
    chk("R1 txFlushPulse", txFlushPulse, 0);
    @(negedge clk);

    // R10 pushes ignored while disabled
    step(0, 0, 1, 8'hAA, 0);
    chk("R10 ignored push", fillLevel, 0);

    // R2 enable, threshold 4 (sel 1); tx pulse follows
    step(1, 8'h41, 0, 0, 0);
    chk("R2 tx pulse on enable", txFlushPulse, 1);
    idle();
    chk("R4 pulse one cycle", txFlushPulse, 0);

    // R5/R6 threshold 4
    for (int i = 0; i < 3; i++) step(0, 0, 1, 8'(8'h10 + i), 0);
    chk("R5 below thr4", rxIrq, 0);
    step(0, 0, 1, 8'h13, 0);
    chk("R5 at thr4", rxIrq, 1);

    // R7/R8 fill to 16 then overrun, even with pop in same cycle
    for (int i = 4; i < 16; i++) step(0, 0, 1, 8'(8'h10 + i), 0);
    chk("R7 full", fifoFull, 1);
    step(0, 0, 1, 8'hEE, 1);
    chk("R8 drop with pop", fillLevel, 15);
    chk("R8 overrun set", overrun, 1);
    chk("R12 oldest first", popData, 8'h10);

    // R4 bit 2 only: pulse, contents kept; write threshold 14 (sel 3)
    step(1, 8'hC5, 0, 0, 0);
    chk("R4 tx flush write", txFlushPulse, 1);
    chk("R4 rx untouched", fillLevel, 15);
    chk("R5 thr14", rxIrq, 1);

    // R3 self-clearing: write without bit1 keeps contents
    step(1, 8'hC1, 0, 0, 0);
    chk("R3 no stored flush", fillLevel, 15);
    chk("R4 no pulse", txFlushPulse, 0);

    // R11 flush with push and pop together
    step(1, 8'h03, 1, 8'h77, 1);
    chk("R11 flush wins", fillLevel, 0);
    chk("R11 popData kept", popData, 8'h10);
    chk("R3 overrun cleared", overrun, 0);

    // R9 pop while empty
    step(0, 0, 0, 0, 1);
    chk("R9 empty pop data", popData, 8'h10);
    chk("R9 empty pop level", fillLevel, 0);

    // R2 disable empties
    step(0, 0, 1, 8'h21, 0);
    step(1, 8'h00, 0, 0, 0);
    chk("R2 disable empties", fillLevel, 0);
    chk("R6 irq off disabled", rxIrq, 0);
    step(1, 8'h01, 0, 0, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, psh, pp;
      logic [7:0] d;
      wr  = ($urandom_range(0, 39) == 0);
      d   = 8'($urandom());
      if ($urandom_range(0, 3) != 0) d[0] = mEn;
      if ($urandom_range(0, 2) != 0) d[1] = 0;
      psh = ($urandom_range(0, 9) < ((n / 300) % 2 == 0 ? 7 : 3));
      pp  = ($urandom_range(0, 9) < ((n / 300) % 2 == 0 ? 3 : 7));
      step(wr, d, psh, 8'($urandom()), pp);
    end
    finishRun();
  end
endmodule